// File: doc/BRIEF.md
# Macroblock Pipeline Stage Sequencer

This block controls a four-stage macroblock pipeline in a video encoder. The first stage fetches the pixels and reference data that prediction needs. The second stage performs prediction, and the last two stages are transform/quantization and entropy coding. Each stage unit is started with a one-cycle start pulse and reports completion with a one-cycle done pulse. A stage may only take a new macroblock when every occupied stage has reported done for its current one, so all stages move together.

The prediction stage holds two units. The intra unit has its own handshake. The inter unit covers integer and fractional motion search and motion compensation over a shared search window, and it uses the stage-vector handshake bit of the prediction stage. A per-macroblock mode selects one of three schedules:
- intra alone, with the inter unit gated off;
- inter alone, with the intra unit gated off;
- a mixed schedule in which both units run together.

In the mixed schedule the intra result is written first into a single shared transform-interface buffer, and the intra unit is gated off. Once the inter result is ready, the buffer is invalidated and then rewritten with the inter result. The sequencer drives the power enables of both prediction units, the buffer write selects, the invalidate pulse and the buffer-valid flag.

Top module: `enc_pipe_ctrl`

## Requirements
- R1: While reset is high, all stage-valid flags, the buffer-valid flag, both power enables and all start and buffer pulses are low from the next clock edge.
- R2: The pipeline advances only when every occupied stage has reported done. A done pulse is seen at the next edge, and the advance happens one cycle after that. On an advance, stage 0 takes `mb_pending` and each later stage takes the occupancy of the stage before it. `stg_start` pulses, one cycle after the advance, for each stage that is now occupied.
- R3: `pred_mode` is sampled in the advance cycle that moves a macroblock into prediction (stage 1). The encodings are: 2'b00 = intra only, 2'b01 = inter only, 2'b10 and 2'b11 = mixed.
- R4: In intra-only mode, `intra_start` pulses on entry, the inter unit is not started (`stg_start[1]` stays low), and `inter_pwr_en` stays low for the whole macroblock. Inter-only mode mirrors this with the roles swapped. A done pulse from the unused unit has no effect.
- R5: In mixed mode, `intra_start` and `stg_start[1]` pulse in the same cycle, and both power enables are high from that cycle.
- R6: One cycle after `intra_done`, `buf_wr_intra` pulses, `buf_valid` goes high and `intra_pwr_en` goes low.
- R7: In mixed mode, once the inter unit has finished and the intra result is stored, `buf_inval` pulses with `buf_valid` low. In the next cycle, `buf_wr_inter` pulses with `buf_valid` high and `inter_pwr_en` low. The pulse comes two cycles after the later of the two done pulses.
- R8: If the inter unit finishes before the intra unit in mixed mode, its result is held with the unit still powered. No invalidate or inter write occurs before the intra write.
- R9: In inter-only mode, `buf_wr_inter` pulses two cycles after the inter done pulse, and no invalidate is issued.
- R10: An advance clears `buf_valid`, because the buffer contents pass to the transform stage.
- R11: A done pulse on a stage that is unoccupied, or that has already reported done, is ignored. It does not count toward a later macroblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_pending | input | 1 | A new macroblock is ready to enter stage 0 |
| pred_mode | input | 2 | Prediction schedule for the macroblock entering stage 1 |
| stg_done | input | N_STAGES | Per-stage done pulses; bit 1 is the inter unit's done |
| intra_done | input | 1 | Intra unit done pulse |
| stg_start | output | N_STAGES | Per-stage start pulses; bit 1 is the inter unit's start |
| stg_valid | output | N_STAGES | Stage occupancy flags |
| intra_start | output | 1 | Intra unit start pulse |
| intra_pwr_en | output | 1 | Intra unit power enable |
| inter_pwr_en | output | 1 | Inter unit power enable |
| buf_wr_intra | output | 1 | Buffer write select for the intra result |
| buf_wr_inter | output | 1 | Buffer write select for the inter result |
| buf_inval | output | 1 | Buffer invalidate pulse |
| buf_valid | output | 1 | Shared buffer holds a valid result |

## Verification
The bench builds the block with its defaults: four stages, with prediction in stage 1. At that size, every mode encoding, including the alias 2'b11, can be crossed with every pair of intra and inter finish delays from 0 to 3 cycles, which gives 64 single-macroblock runs. Those runs cover the inter-before-intra hold, simultaneous finishes and stray done pulses from the unused unit. For each run, the bench checks the power enables, the buffer pulses and the valid flag cycle by cycle against closed-form finish times. A separate two-macroblock run checks the lockstep stall and the rejection of early done pulses.

// File: rtl/enc_pipe_pkg.sv
package enc_pipe_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_SEP_INTRA = 2'b00,
    PM_SEP_INTER = 2'b01,
    PM_MIXED     = 2'b10,
    PM_MIXED_ALT = 2'b11
  } pred_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_WRINT = 2'd2,
    PH_DONE  = 2'd3
  } pred_phase_e;

  function automatic logic mode_uses_intra(pred_mode_e m);
    return m != PM_SEP_INTER;
  endfunction

  function automatic logic mode_uses_inter(pred_mode_e m);
    return m != PM_SEP_INTRA;
  endfunction

  function automatic logic mode_is_mixed(pred_mode_e m);
    return (m == PM_MIXED) || (m == PM_MIXED_ALT);
  endfunction
endpackage

// File: rtl/stage_track.sv
module stage_track (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic occ_next,
  input  logic done_in,
  output logic vld,
  output logic start,
  output logic complete
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= 1'b0;
      start  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      start <= 1'b0;
      if (adv) begin
        vld    <= occ_next;
        start  <= occ_next;
        done_q <= 1'b0;
      end else if (vld && done_in) begin
        done_q <= 1'b1;
      end
    end
  end

  assign complete = !vld || done_q;

  // R11: a stage that is empty never reports itself finished through a latched done
  p_empty_no_done_r11: assert property (@(posedge clk) disable iff (rst)
    !vld |-> !done_q);
endmodule

// File: rtl/pred_sched.sv
module pred_sched
  import enc_pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              enter,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              intra_done,
  input  logic              inter_done,
  output logic              vld,
  output logic              intra_start,
  output logic              inter_start,
  output logic              intra_pwr,
  output logic              inter_pwr,
  output logic              wr_intra,
  output logic              wr_inter,
  output logic              inval,
  output logic              buf_valid,
  output logic              complete
);
  pred_mode_e  mode_q;
  pred_phase_e phase;
  logic        intra_fin;
  logic        inter_pend;
  pred_mode_e  mode_new;

  assign mode_new = pred_mode_e'(mode_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld         <= 1'b0;
      mode_q      <= PM_SEP_INTRA;
      phase       <= PH_IDLE;
      intra_start <= 1'b0;
      inter_start <= 1'b0;
      intra_pwr   <= 1'b0;
      inter_pwr   <= 1'b0;
      wr_intra    <= 1'b0;
      wr_inter    <= 1'b0;
      inval       <= 1'b0;
      buf_valid   <= 1'b0;
      intra_fin   <= 1'b0;
      inter_pend  <= 1'b0;
    end else begin
      intra_start <= 1'b0;
      inter_start <= 1'b0;
      wr_intra    <= 1'b0;
      wr_inter    <= 1'b0;
      inval       <= 1'b0;
      if (adv) begin
        vld         <= enter;
        mode_q      <= mode_new;
        phase       <= enter ? PH_RUN : PH_IDLE;
        intra_start <= enter && mode_uses_intra(mode_new);
        inter_start <= enter && mode_uses_inter(mode_new);
        intra_pwr   <= enter && mode_uses_intra(mode_new);
        inter_pwr   <= enter && mode_uses_inter(mode_new);
        intra_fin   <= 1'b0;
        inter_pend  <= 1'b0;
        buf_valid   <= 1'b0;
      end else begin
        case (phase)
          PH_RUN: begin
            if (intra_done && intra_pwr) begin
              intra_pwr <= 1'b0;
              wr_intra  <= 1'b1;
              buf_valid <= 1'b1;
              intra_fin <= 1'b1;
              if (mode_q == PM_SEP_INTRA) phase <= PH_DONE;
            end
            if (inter_done && inter_pwr) inter_pend <= 1'b1;
            if (inter_pend) begin
              if (mode_q == PM_SEP_INTER) begin
                wr_inter  <= 1'b1;
                buf_valid <= 1'b1;
                inter_pwr <= 1'b0;
                phase     <= PH_DONE;
              end else if (intra_fin) begin
                inval     <= 1'b1;
                buf_valid <= 1'b0;
                phase     <= PH_WRINT;
              end
            end
          end
          PH_WRINT: begin
            wr_inter  <= 1'b1;
            buf_valid <= 1'b1;
            inter_pwr <= 1'b0;
            phase     <= PH_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign complete = !vld || (phase == PH_DONE);

  // R7: the buffer sees at most one operation per cycle
  p_bufop_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_intra, wr_inter, inval}));
  // R7: an invalidate is always followed by the inter write
  p_inval_then_write_r7: assert property (@(posedge clk) disable iff (rst)
    inval |=> wr_inter);
  // R7: in the mixed schedule the inter write comes right after an invalidate
  p_mixed_wr_after_inval_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_inter && mode_is_mixed(mode_q)) |-> $past(inval));
  // R6: the intra unit is gated off once its result is in the buffer
  p_intra_off_r6: assert property (@(posedge clk) disable iff (rst)
    wr_intra |-> (!intra_pwr && buf_valid));
  // R4: separate schedules keep the other unit gated
  p_sep_intra_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (vld && mode_q == PM_SEP_INTRA) |-> !inter_pwr);
  p_sep_inter_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (vld && mode_q == PM_SEP_INTER) |-> !intra_pwr);
  // R8: no invalidate while the intra result is still outstanding
  p_hold_inter_r8: assert property (@(posedge clk) disable iff (rst)
    (inval && mode_is_mixed(mode_q)) |-> !intra_pwr);
endmodule

// File: rtl/enc_pipe_ctrl.sv
module enc_pipe_ctrl
  import enc_pipe_pkg::*;
#(
  parameter int N_STAGES   = 4,
  parameter int PRED_STAGE = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mb_pending,
  input  logic [MODE_W-1:0]   pred_mode,
  input  logic [N_STAGES-1:0] stg_done,
  input  logic                intra_done,
  output logic [N_STAGES-1:0] stg_start,
  output logic [N_STAGES-1:0] stg_valid,
  output logic                intra_start,
  output logic                intra_pwr_en,
  output logic                inter_pwr_en,
  output logic                buf_wr_intra,
  output logic                buf_wr_inter,
  output logic                buf_inval,
  output logic                buf_valid
);
  logic [N_STAGES-1:0] occ_next;
  logic [N_STAGES-1:0] complete;
  logic                adv;

  assign adv = &complete;

  genvar gi;
  generate
    for (gi = 0; gi < N_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign occ_next[gi] = mb_pending;
      end else begin : g_tail
        assign occ_next[gi] = stg_valid[gi-1];
      end

      if (gi == PRED_STAGE) begin : g_pred
        pred_sched u_pred (
          .clk        (clk),
          .rst        (rst),
          .adv        (adv),
          .enter      (occ_next[gi]),
          .mode_in    (pred_mode),
          .intra_done (intra_done),
          .inter_done (stg_done[gi]),
          .vld        (stg_valid[gi]),
          .intra_start(intra_start),
          .inter_start(stg_start[gi]),
          .intra_pwr  (intra_pwr_en),
          .inter_pwr  (inter_pwr_en),
          .wr_intra   (buf_wr_intra),
          .wr_inter   (buf_wr_inter),
          .inval      (buf_inval),
          .buf_valid  (buf_valid),
          .complete   (complete[gi])
        );
      end else begin : g_plain
        stage_track u_trk (
          .clk     (clk),
          .rst     (rst),
          .adv     (adv),
          .occ_next(occ_next[gi]),
          .done_in (stg_done[gi]),
          .vld     (stg_valid[gi]),
          .start   (stg_start[gi]),
          .complete(complete[gi])
        );
      end
    end
  endgenerate

  // R1: reset clears occupancy, buffer state and gates
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (stg_valid == '0 && !buf_valid && !intra_pwr_en && !inter_pwr_en));
  // R2: without an advance, occupancy holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(stg_valid));
  // R2: an advance shifts occupancy by one stage
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    adv |=> (stg_valid == {$past(stg_valid[N_STAGES-2:0]), $past(mb_pending)}));
  // R10: an advance empties the shared buffer
  p_adv_clears_buf_r10: assert property (@(posedge clk) disable iff (rst)
    adv |=> !buf_valid);
endmodule

// File: tb/enc_pipe_ctrl_test.sv
module enc_pipe_ctrl_test;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mb_pending = 1'b0;
  logic [1:0]    pred_mode = 2'b00;
  logic [NS-1:0] stg_done = '0;
  logic          intra_done = 1'b0;
  logic [NS-1:0] stg_start, stg_valid;
  logic          intra_start, intra_pwr_en, inter_pwr_en;
  logic          buf_wr_intra, buf_wr_inter, buf_inval, buf_valid;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  enc_pipe_ctrl #(.N_STAGES(NS), .PRED_STAGE(1)) uut (
    .clk(clk), .rst(rst), .mb_pending(mb_pending), .pred_mode(pred_mode),
    .stg_done(stg_done), .intra_done(intra_done), .stg_start(stg_start),
    .stg_valid(stg_valid), .intra_start(intra_start),
    .intra_pwr_en(intra_pwr_en), .inter_pwr_en(inter_pwr_en),
    .buf_wr_intra(buf_wr_intra), .buf_wr_inter(buf_wr_inter),
    .buf_inval(buf_inval), .buf_valid(buf_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // one macroblock through an empty pipeline
  task automatic run_mb(input int mode, input int ti, input int tj);
    bit ui, ue, mx;
    int kinv, tend;
    logic [5:0] exp_v, act_v;
    string tag;
    ui = (mode != 1);
    ue = (mode != 0);
    mx = (mode >= 2);
    kinv = ((ti > tj) ? ti : tj) + 2;
    if (mode == 0)      tend = ti + 1;
    else if (mode == 1) tend = tj + 2;
    else                tend = kinv + 1;
    tag = (mode == 0) ? "R6" : (mode == 1) ? "R9" : (ti > tj) ? "R8" : "R7";

    pred_mode = mode[1:0];
    mb_pending = 1'b1;
    nxt();
    chk(stg_valid == 4'b0001 && stg_start == 4'b0001, "R2 entry", {stg_valid, stg_start}, 8'h11);
    mb_pending = 1'b0;
    stg_done[0] = 1'b1;
    nxt();
    stg_done[0] = 1'b0;
    nxt();
    chk(intra_start == ui && stg_start[1] == ue, mx ? "R5 starts" : "R4 starts",
        {intra_start, stg_start[1]}, {ui, ue});
    for (int k = 0; k <= tend; k++) begin
      exp_v[5] = ui && (k <= ti);
      exp_v[4] = ue && (k < tend);
      exp_v[3] = ui && (k == ti + 1);
      exp_v[2] = ue && (k == tend);
      exp_v[1] = mx && (k == kinv);
      if (mode == 0)      exp_v[0] = (k >= ti + 1);
      else if (mode == 1) exp_v[0] = (k >= tend);
      else                exp_v[0] = (k >= ti + 1) && (k != kinv);
      act_v = {intra_pwr_en, inter_pwr_en, buf_wr_intra, buf_wr_inter, buf_inval, buf_valid};
      chk(act_v == exp_v, tag, act_v, exp_v);
      intra_done  = (k == ti) && (k < tend);
      stg_done[1] = (k == tj) && (k < tend);
      nxt();
    end
    intra_done = 1'b0;
    stg_done[1] = 1'b0;
    chk(stg_valid == 4'b0100 && stg_start == 4'b0100 && !buf_valid && !intra_pwr_en && !inter_pwr_en,
        "R10 handoff", {stg_valid, stg_start, buf_valid}, 9'h088);
    stg_done[2] = 1'b1;
    nxt();
    stg_done[2] = 1'b0;
    nxt();
    chk(stg_valid == 4'b1000 && stg_start == 4'b1000, "R2 to stage3", {stg_valid, stg_start}, 8'h88);
    stg_done[3] = 1'b1;
    nxt();
    stg_done[3] = 1'b0;
    nxt();
    chk(stg_valid == 4'b0000, "R2 drain", stg_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    nxt();
    nxt();
    chk(stg_valid == 0 && !buf_valid && !intra_pwr_en && !inter_pwr_en && stg_start == 0 &&
        !buf_wr_intra && !buf_wr_inter && !buf_inval && !intra_start, "R1 reset",
        {stg_valid, buf_valid, intra_pwr_en, inter_pwr_en}, 0);
    rst = 1'b0;
    nxt();

    // R3 R4 R5 R6 R7 R8 R9 R10: all modes against all finish delays
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          run_mb(m, a, b);

    // R11: stray done pulses into an empty pipeline
    stg_done = 4'b1110;
    intra_done = 1'b1;
    nxt();
    stg_done = '0;
    intra_done = 1'b0;
    // R2: lockstep with two macroblocks
    pred_mode = 2'b00;
    mb_pending = 1'b1;
    nxt();
    chk(stg_valid == 4'b0001, "R11 stray ignored", stg_valid, 1);
    stg_done[0] = 1'b1;
    nxt();
    stg_done[0] = 1'b0;
    nxt();
    chk(stg_valid == 4'b0011 && stg_start == 4'b0001 && intra_start, "R2 second entry",
        {stg_valid, stg_start}, 8'h31);
    mb_pending = 1'b0;
    stg_done[0] = 1'b1;
    nxt();
    stg_done[0] = 1'b0;
    for (int w = 0; w < 3; w++) begin
      nxt();
      chk(stg_valid == 4'b0011, "R2 stall on prediction", stg_valid, 3);
    end
    intra_done = 1'b1;
    nxt();
    intra_done = 1'b0;
    chk(buf_wr_intra == 1'b1, "R6 lockstep write", buf_wr_intra, 1);
    nxt();
    chk(stg_valid == 4'b0110 && stg_start == 4'b0100 && intra_start, "R2 lockstep advance",
        {stg_valid, stg_start}, 8'h64);
    intra_done = 1'b1;
    nxt();
    intra_done = 1'b0;
    for (int w = 0; w < 3; w++) begin
      nxt();
      chk(stg_valid == 4'b0110, "R11 early stage2 done not kept", stg_valid, 6);
    end
    stg_done[2] = 1'b1;
    nxt();
    stg_done[2] = 1'b0;
    nxt();
    chk(stg_valid == 4'b1100, "R2 shift to stage3", stg_valid, 12);
    stg_done[3] = 1'b1;
    nxt();
    stg_done[3] = 1'b0;
    for (int w = 0; w < 2; w++) begin
      nxt();
      chk(stg_valid == 4'b1100, "R2 stall on stage2", stg_valid, 12);
    end
    stg_done[2] = 1'b1;
    nxt();
    stg_done[2] = 1'b0;
    nxt();
    chk(stg_valid == 4'b1000, "R2 drain step", stg_valid, 8);
    stg_done[3] = 1'b1;
    nxt();
    stg_done[3] = 1'b0;
    nxt();
    chk(stg_valid == 4'b0000, "R2 empty", stg_valid, 0);

    // R1: reset mid-flight
    mb_pending = 1'b1;
    nxt();
    rst = 1'b1;
    mb_pending = 1'b0;
    nxt();
    chk(stg_valid == 0 && stg_start == 0, "R1 reset mid-flight", {stg_valid, stg_start}, 0);
    rst = 1'b0;
    nxt();

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule